// File: doc/BRIEF.md
# Capability Memory Access Checker

This unit decides, one cycle before a data access issues, whether the authorising capability allows it. The access can be a load, a store, an atomic, one of four cache-block maintenance operations (clean, flush, invalidate, zero) or a read or write prefetch. The unit is given the capability's tag, sealed flag, read and write permissions and its base and top bounds. It is also given the program counter capability's system-register permission, the access address and size, an operation code, a capability-width flag and the taggable attribute of the target region.

A request strobed with `req_valid` produces a registered result on the following clock edge. If several checks fail, only the one with the highest priority is reported. The order is tag, then seal, then permission, then bounds, then alignment. Prefetches never raise an exception. A prefetch that fails a check is flagged to be dropped. A load from a region that cannot hold tags is flagged so that the returned tag is cleared. Cache-block operations check the whole naturally aligned block that contains the address, and the block size is a parameter.

Top module: `cap_access_checker`

## Requirements
- R1: For every non-prefetch operation (op codes 0..6), a clear capability tag raises an exception with `exc_code` = CHERI_CODE (default 28) and `cheri_cause` = 4'h1.
- R2: For every non-prefetch operation, a tagged but sealed capability raises an exception with cause 4'h2.
- R3: Read permission is required by load (op 0), atomic (op 2) and block-invalidate (op 5). Write permission is required by store (op 1), atomic, block-invalidate and block-zero (op 6). A missing permission gives cause 4'h3.
- R4: Block-clean (op 3) and block-flush (op 4) give a permission fault (cause 4'h3) only when the capability has neither read nor write permission.
- R5: Block-invalidate with the program counter capability's system-register permission clear faults with the PCC fault type, cause 4'h B (bit 3 marks the PCC type, low bits 3 mean permission). An authorising-capability permission fault is reported in preference to it.
- R6: For load, store and atomic, any byte of [addr, addr+size) outside [base, top) gives cause 4'h4. The size is 2^`req_size_lg` bytes, or CAP_BYTES when `req_cap_width` is set.
- R7: Block-zero and block-invalidate give cause 4'h4 if any byte of the BLK_BYTES-aligned block holding the address lies outside the bounds. Block-clean and block-flush give cause 4'h4 only if no byte of the block is in bounds.
- R8: A capability-width load whose address is not CAP_BYTES-aligned raises `exc_code` 4, and a capability-width store raises `exc_code` 6. In both cases `cheri_cause` is 0.
- R9: Only the highest-priority failure is reported, in the order tag, seal, permission, bounds, alignment.
- R10: Prefetch read (op 7) and prefetch write (op 8) never raise an exception. `pf_drop` is set when the tag is clear, the capability is sealed, the matching read or write permission is missing, or no byte of the block is in bounds.
- R11: `tag_strip` is set for a non-faulting load when `region_taggable` is low, and is low for every other result.
- R12: Results appear exactly one cycle after `req_valid`. When `rsp_valid` is low, and after reset, all result outputs are zero. Op codes 9..15 produce a response with no exception, no drop and no strip.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request strobe |
| req_op | input | 4 | Operation code (0 load, 1 store, 2 atomic, 3 clean, 4 flush, 5 invalidate, 6 zero, 7 prefetch read, 8 prefetch write) |
| req_addr | input | ADDR_W | Access address |
| req_size_lg | input | 3 | Log2 of access size in bytes |
| req_cap_width | input | 1 | Access is capability width |
| auth_tag | input | 1 | Authorising capability tag |
| auth_sealed | input | 1 | Authorising capability is sealed |
| auth_rd | input | 1 | Read permission |
| auth_wr | input | 1 | Write permission |
| auth_base | input | ADDR_W+1 | Lower bound (inclusive) |
| auth_top | input | ADDR_W+1 | Upper bound (exclusive) |
| pcc_sysreg | input | 1 | Program counter capability system-register permission |
| region_taggable | input | 1 | Target region can hold tags |
| rsp_valid | output | 1 | Result valid |
| exc_valid | output | 1 | Exception raised |
| exc_code | output | 5 | Exception code |
| cheri_cause | output | 4 | {PCC type, fault kind} |
| pf_drop | output | 1 | Prefetch must be dropped |
| tag_strip | output | 1 | Clear tag of loaded data |

## Verification
On every cycle the assertions check the tag and seal precedence and the response timing. They also check that prefetches never trap, that the drop and strip flags appear only for their own operation classes, and that the alignment codes come with a zero cause. The bench's scenarios are what show the permission matrix per operation, the bounds rules for partial and fully outside blocks, and exact byte-level bounds edges. They also cover the ordering of lower-priority faults, such as bounds ahead of alignment and an authorising-capability permission fault ahead of the program counter permission fault.

// File: rtl/capchk_pkg.sv
package capchk_pkg;

   typedef enum logic [3:0] {
      OP_LOAD      = 4'd0,
      OP_STORE     = 4'd1,
      OP_AMO       = 4'd2,
      OP_BLK_CLEAN = 4'd3,
      OP_BLK_FLUSH = 4'd4,
      OP_BLK_INVAL = 4'd5,
      OP_BLK_ZERO  = 4'd6,
      OP_PF_RD     = 4'd7,
      OP_PF_WR     = 4'd8
   } mem_op_e;

   typedef enum logic [2:0] {
      FK_NONE = 3'd0,
      FK_TAG  = 3'd1,
      FK_SEAL = 3'd2,
      FK_PERM = 3'd3,
      FK_LEN  = 3'd4
   } fault_kind_e;

   typedef struct packed {
      logic known;
      logic is_blk;
      logic is_pf;
      logic need_r;
      logic need_w;
      logic need_either;
      logic need_pcc;
      logic len_all_out;
      logic is_load;
      logic is_store;
   } op_class_t;

   function automatic op_class_t decode_op(input logic [3:0] op);
      op_class_t c;
      c = '0;
      c.known = 1'b1;
      unique case (op)
         OP_LOAD:      begin c.need_r = 1'b1; c.is_load = 1'b1; end
         OP_STORE:     begin c.need_w = 1'b1; c.is_store = 1'b1; end
         OP_AMO:       begin c.need_r = 1'b1; c.need_w = 1'b1; end
         OP_BLK_CLEAN,
         OP_BLK_FLUSH: begin c.is_blk = 1'b1; c.need_either = 1'b1; c.len_all_out = 1'b1; end
         OP_BLK_INVAL: begin c.is_blk = 1'b1; c.need_r = 1'b1; c.need_w = 1'b1; c.need_pcc = 1'b1; end
         OP_BLK_ZERO:  begin c.is_blk = 1'b1; c.need_w = 1'b1; end
         OP_PF_RD:     begin c.is_blk = 1'b1; c.is_pf = 1'b1; c.need_r = 1'b1; c.len_all_out = 1'b1; end
         OP_PF_WR:     begin c.is_blk = 1'b1; c.is_pf = 1'b1; c.need_w = 1'b1; c.len_all_out = 1'b1; end
         default:      c.known = 1'b0;
      endcase
      return c;
   endfunction

endpackage

// File: rtl/capchk_perm.sv
module capchk_perm
   import capchk_pkg::*;
(
   input  op_class_t cls,
   input  logic      perm_r,
   input  logic      perm_w,
   input  logic      pcc_sys,
   output logic      auth_fail,
   output logic      pcc_fail
);

   logic miss_r, miss_w, miss_both;

   always_comb begin
      miss_r    = cls.need_r & ~perm_r;
      miss_w    = cls.need_w & ~perm_w;
      miss_both = cls.need_either & ~perm_r & ~perm_w;
      auth_fail = miss_r | miss_w | miss_both;
      pcc_fail  = cls.need_pcc & ~pcc_sys;
   end

endmodule

// File: rtl/capchk_bounds.sv
module capchk_bounds #(
   parameter int ADDR_W    = 32,
   parameter int BLK_BYTES = 64,
   parameter int CAP_BYTES = 8
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic [2:0]        size_lg,
   input  logic              cap_width,
   input  logic [ADDR_W:0]   base,
   input  logic [ADDR_W:0]   top,
   output logic              acc_in,
   output logic              blk_all_in,
   output logic              blk_overlap,
   output logic              misaligned
);

   localparam int EW     = ADDR_W + 1;
   localparam int BLK_LG = $clog2(BLK_BYTES);
   localparam int CAP_LG = $clog2(CAP_BYTES);

   logic [EW-1:0] acc_lo, acc_len, acc_end, blk_lo, blk_hi;

   always_comb begin
      acc_lo  = {1'b0, addr};
      acc_len = cap_width ? EW'(CAP_BYTES) : (EW'(1) << size_lg);
      acc_end = acc_lo + acc_len;
      blk_lo  = {1'b0, addr[ADDR_W-1:BLK_LG], {BLK_LG{1'b0}}};
      blk_hi  = blk_lo + EW'(BLK_BYTES);

      acc_in      = (acc_lo >= base) && (acc_end <= top);
      blk_all_in  = (blk_lo >= base) && (blk_hi <= top);
      blk_overlap = (base < top) && (blk_lo < top) && (blk_hi > base);
   end

   generate
      if (CAP_LG == 0) begin : g_no_align
         assign misaligned = 1'b0;
      end else begin : g_align
         assign misaligned = cap_width && (addr[CAP_LG-1:0] != '0);
      end
   endgenerate

endmodule

// File: rtl/capchk_prio.sv
module capchk_prio
   import capchk_pkg::*;
#(
   parameter int CHERI_CODE = 28
) (
   input  op_class_t   cls,
   input  logic        tag,
   input  logic        sealed,
   input  logic        auth_perm_fail,
   input  logic        pcc_perm_fail,
   input  logic        acc_in,
   input  logic        blk_all_in,
   input  logic        blk_overlap,
   input  logic        misaligned,
   input  logic        region_taggable,
   output logic        exc,
   output logic [4:0]  code,
   output logic [3:0]  cause,
   output logic        drop,
   output logic        strip
);

   logic        len_fail;
   fault_kind_e kind;
   logic        pcc_type;

   always_comb begin
      if (cls.is_blk)
         len_fail = cls.len_all_out ? ~blk_overlap : ~blk_all_in;
      else
         len_fail = ~acc_in;

      pcc_type = 1'b0;
      if (!tag)                 kind = FK_TAG;
      else if (sealed)          kind = FK_SEAL;
      else if (auth_perm_fail)  kind = FK_PERM;
      else if (pcc_perm_fail) begin
         kind     = FK_PERM;
         pcc_type = 1'b1;
      end
      else if (len_fail)        kind = FK_LEN;
      else                      kind = FK_NONE;

      exc   = 1'b0;
      code  = 5'd0;
      cause = 4'd0;
      drop  = 1'b0;
      strip = 1'b0;
      if (cls.known) begin
         if (cls.is_pf) begin
            drop = (kind != FK_NONE);
         end else if (kind != FK_NONE) begin
            exc   = 1'b1;
            code  = 5'(CHERI_CODE);
            cause = {pcc_type, kind};
         end else if (misaligned && cls.is_load) begin
            exc  = 1'b1;
            code = 5'd4;
         end else if (misaligned && cls.is_store) begin
            exc  = 1'b1;
            code = 5'd6;
         end
         strip = cls.is_load & ~region_taggable & ~exc;
      end
   end

endmodule

// File: rtl/cap_access_checker.sv
module cap_access_checker
   import capchk_pkg::*;
#(
   parameter int ADDR_W     = 32,
   parameter int BLK_BYTES  = 64,
   parameter int CAP_BYTES  = 8,
   parameter int CHERI_CODE = 28
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [3:0]        req_op,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [2:0]        req_size_lg,
   input  logic              req_cap_width,
   input  logic              auth_tag,
   input  logic              auth_sealed,
   input  logic              auth_rd,
   input  logic              auth_wr,
   input  logic [ADDR_W:0]   auth_base,
   input  logic [ADDR_W:0]   auth_top,
   input  logic              pcc_sysreg,
   input  logic              region_taggable,
   output logic              rsp_valid,
   output logic              exc_valid,
   output logic [4:0]        exc_code,
   output logic [3:0]        cheri_cause,
   output logic              pf_drop,
   output logic              tag_strip
);

   localparam int BLK_LG = $clog2(BLK_BYTES);

   generate
      if ((1 << BLK_LG) != BLK_BYTES || BLK_BYTES < CAP_BYTES) begin : g_bad_blk
         $error("BLK_BYTES must be a power of two no smaller than CAP_BYTES");
      end
      if ((1 << $clog2(CAP_BYTES)) != CAP_BYTES) begin : g_bad_cap
         $error("CAP_BYTES must be a power of two");
      end
      if (ADDR_W <= BLK_LG) begin : g_bad_aw
         $error("ADDR_W must exceed log2 of BLK_BYTES");
      end
      if (CHERI_CODE < 0 || CHERI_CODE > 31) begin : g_bad_code
         $error("CHERI_CODE must fit in five bits");
      end
   endgenerate

   op_class_t  cls;
   logic       auth_fail, pcc_fail;
   logic       acc_in, blk_all_in, blk_overlap, misaligned;
   logic       n_exc, n_drop, n_strip;
   logic [4:0] n_code;
   logic [3:0] n_cause;

   assign cls = decode_op(req_op);

   capchk_perm u_perm (
      .cls       (cls),
      .perm_r    (auth_rd),
      .perm_w    (auth_wr),
      .pcc_sys   (pcc_sysreg),
      .auth_fail (auth_fail),
      .pcc_fail  (pcc_fail)
   );

   capchk_bounds #(
      .ADDR_W    (ADDR_W),
      .BLK_BYTES (BLK_BYTES),
      .CAP_BYTES (CAP_BYTES)
   ) u_bounds (
      .addr        (req_addr),
      .size_lg     (req_size_lg),
      .cap_width   (req_cap_width),
      .base        (auth_base),
      .top         (auth_top),
      .acc_in      (acc_in),
      .blk_all_in  (blk_all_in),
      .blk_overlap (blk_overlap),
      .misaligned  (misaligned)
   );

   capchk_prio #(
      .CHERI_CODE (CHERI_CODE)
   ) u_prio (
      .cls             (cls),
      .tag             (auth_tag),
      .sealed          (auth_sealed),
      .auth_perm_fail  (auth_fail),
      .pcc_perm_fail   (pcc_fail),
      .acc_in          (acc_in),
      .blk_all_in      (blk_all_in),
      .blk_overlap     (blk_overlap),
      .misaligned      (misaligned),
      .region_taggable (region_taggable),
      .exc             (n_exc),
      .code            (n_code),
      .cause           (n_cause),
      .drop            (n_drop),
      .strip           (n_strip)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid   <= 1'b0;
         exc_valid   <= 1'b0;
         exc_code    <= '0;
         cheri_cause <= '0;
         pf_drop     <= 1'b0;
         tag_strip   <= 1'b0;
      end else begin
         rsp_valid   <= req_valid;
         exc_valid   <= req_valid & n_exc;
         exc_code    <= req_valid ? n_code : '0;
         cheri_cause <= req_valid ? n_cause : '0;
         pf_drop     <= req_valid & n_drop;
         tag_strip   <= req_valid & n_strip;
      end
   end

endmodule

// File: rtl/capchk_checker.sv
module capchk_checker #(
   parameter int CHERI_CODE = 28
) (
   input logic       clk,
   input logic       rst_n,
   input logic       req_valid,
   input logic [3:0] req_op,
   input logic       auth_tag,
   input logic       auth_sealed,
   input logic       region_taggable,
   input logic       rsp_valid,
   input logic       exc_valid,
   input logic [4:0] exc_code,
   input logic [3:0] cheri_cause,
   input logic       pf_drop,
   input logic       tag_strip
);

   AST_TAG_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !auth_tag && req_op <= 4'd6)
      |=> (exc_valid && exc_code == 5'(CHERI_CODE) && cheri_cause == 4'h1)); // R1

   AST_SEAL_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && auth_tag && auth_sealed && req_op <= 4'd6)
      |=> (exc_valid && cheri_cause == 4'h2)); // R2

   AST_PF_NO_TRAP: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && (req_op == 4'd7 || req_op == 4'd8)) |=> !exc_valid); // R10

   AST_PF_BAD_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_op == 4'd7 && (!auth_tag || auth_sealed)) |=> pf_drop); // R10

   AST_DROP_ONLY_PF: assert property (@(posedge clk) disable iff (!rst_n)
      pf_drop |-> ($past(req_op) == 4'd7 || $past(req_op) == 4'd8)); // R10

   AST_STRIP_LOAD_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
      tag_strip |-> (!exc_valid && $past(req_op) == 4'd0 && !$past(region_taggable))); // R11

   AST_ALIGN_CODE: assert property (@(posedge clk) disable iff (!rst_n)
      (exc_valid && exc_code != 5'(CHERI_CODE))
      |-> (cheri_cause == 4'h0 &&
           ((exc_code == 5'd4 && $past(req_op) == 4'd0) ||
            (exc_code == 5'd6 && $past(req_op) == 4'd1)))); // R8

   AST_RSP_TIMING: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> rsp_valid); // R12

   AST_RSP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !rsp_valid); // R12

   AST_QUIET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !rsp_valid |-> (!exc_valid && !pf_drop && !tag_strip &&
                      exc_code == 5'd0 && cheri_cause == 4'h0)); // R12

endmodule

bind cap_access_checker capchk_checker #(
   .CHERI_CODE (CHERI_CODE)
) u_chk (
   .clk             (clk),
   .rst_n           (rst_n),
   .req_valid       (req_valid),
   .req_op          (req_op),
   .auth_tag        (auth_tag),
   .auth_sealed     (auth_sealed),
   .region_taggable (region_taggable),
   .rsp_valid       (rsp_valid),
   .exc_valid       (exc_valid),
   .exc_code        (exc_code),
   .cheri_cause     (cheri_cause),
   .pf_drop         (pf_drop),
   .tag_strip       (tag_strip)
);

// File: tb/cap_access_checker_tb.sv
module cap_access_checker_tb;

   localparam int AW = 32;
   localparam int CC = 28;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0;
   logic [3:0]    req_op = '0;
   logic [AW-1:0] req_addr = '0;
   logic [2:0]    req_size_lg = '0;
   logic          req_cap_width = 1'b0;
   logic          auth_tag = 1'b1, auth_sealed = 1'b0, auth_rd = 1'b1, auth_wr = 1'b1;
   logic [AW:0]   auth_base = 33'h1000, auth_top = 33'h2000;
   logic          pcc_sysreg = 1'b1, region_taggable = 1'b1;
   logic          rsp_valid, exc_valid, pf_drop, tag_strip;
   logic [4:0]    exc_code;
   logic [3:0]    cheri_cause;

   int total = 0;
   int bad = 0;

   always #5 clk = ~clk;

   cap_access_checker #(.ADDR_W(AW), .BLK_BYTES(64), .CAP_BYTES(8), .CHERI_CODE(CC)) u_dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
      .req_addr(req_addr), .req_size_lg(req_size_lg), .req_cap_width(req_cap_width),
      .auth_tag(auth_tag), .auth_sealed(auth_sealed), .auth_rd(auth_rd), .auth_wr(auth_wr),
      .auth_base(auth_base), .auth_top(auth_top), .pcc_sysreg(pcc_sysreg),
      .region_taggable(region_taggable), .rsp_valid(rsp_valid), .exc_valid(exc_valid),
      .exc_code(exc_code), .cheri_cause(cheri_cause), .pf_drop(pf_drop), .tag_strip(tag_strip)
   );

   task automatic check(input string req, input logic [11:0] got, input logic [11:0] exp);
      total++;
      if (got !== exp) begin
         bad++;
         $display("FAIL %s: got exc/code/cause/drop/strip=%03h expected %03h", req, got, exp);
      end
   endtask

   task automatic cap_default();
      auth_tag = 1'b1; auth_sealed = 1'b0; auth_rd = 1'b1; auth_wr = 1'b1;
      auth_base = 33'h1000; auth_top = 33'h2000; pcc_sysreg = 1'b1; region_taggable = 1'b1;
   endtask

   // drive at a falling edge, result is registered at the next rising edge,
   // sampled at the following falling edge
   task automatic run(input string req, input logic [3:0] op, input logic [AW-1:0] a,
                      input logic [2:0] sz, input logic cw,
                      input logic e_exc, input logic [4:0] e_code, input logic [3:0] e_cause,
                      input logic e_drop, input logic e_strip);
      req_op = op; req_addr = a; req_size_lg = sz; req_cap_width = cw; req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      check(req, {exc_valid, exc_code, cheri_cause, pf_drop, tag_strip},
            {e_exc, e_code, e_cause, e_drop, e_strip});
      total++;
      if (rsp_valid !== 1'b1) begin
         bad++;
         $display("FAIL R12 %s: rsp_valid=%b expected 1", req, rsp_valid);
      end
   endtask

   task automatic t_reset();
      check("R12 reset", {exc_valid, exc_code, cheri_cause, pf_drop, tag_strip}, 12'h000);
      total++;
      if (rsp_valid !== 1'b0) begin bad++; $display("FAIL R12 reset rsp_valid=%b expected 0", rsp_valid); end
   endtask

   task automatic t_tag();
      cap_default(); auth_tag = 1'b0;
      run("R1 store untagged", 4'd1, 32'h1100, 3'd2, 1'b0, 1, CC, 4'h1, 0, 0);
      auth_sealed = 1'b1; auth_rd = 1'b0; auth_wr = 1'b0;
      run("R1 R9 tag beats seal/perm", 4'd5, 32'h1100, 3'd0, 1'b0, 1, CC, 4'h1, 0, 0);
      cap_default();
   endtask

   task automatic t_seal();
      cap_default(); auth_sealed = 1'b1; auth_wr = 1'b0;
      run("R2 R9 seal beats perm", 4'd1, 32'h1100, 3'd2, 1'b0, 1, CC, 4'h2, 0, 0);
      run("R2 sealed clean", 4'd3, 32'h1100, 3'd0, 1'b0, 1, CC, 4'h2, 0, 0);
      cap_default();
   endtask

   task automatic t_perm();
      cap_default(); auth_wr = 1'b0;
      run("R3 store no write", 4'd1, 32'h1100, 3'd2, 1'b0, 1, CC, 4'h3, 0, 0);
      run("R3 load ok without write", 4'd0, 32'h1100, 3'd2, 1'b0, 0, 0, 4'h0, 0, 0);
      cap_default(); auth_rd = 1'b0;
      run("R3 load no read", 4'd0, 32'h1100, 3'd2, 1'b0, 1, CC, 4'h3, 0, 0);
      run("R3 amo no read", 4'd2, 32'h1100, 3'd2, 1'b0, 1, CC, 4'h3, 0, 0);
      run("R3 zero needs only write", 4'd6, 32'h1100, 3'd0, 1'b0, 0, 0, 4'h0, 0, 0);
      auth_base = 33'h1010;
      run("R3 R9 perm beats length", 4'd0, 32'h1000, 3'd2, 1'b0, 1, CC, 4'h3, 0, 0);
      cap_default();
   endtask

   task automatic t_clean_perm();
      cap_default(); auth_rd = 1'b0;
      run("R4 clean write only", 4'd3, 32'h1100, 3'd0, 1'b0, 0, 0, 4'h0, 0, 0);
      auth_rd = 1'b1; auth_wr = 1'b0;
      run("R4 flush read only", 4'd4, 32'h1100, 3'd0, 1'b0, 0, 0, 4'h0, 0, 0);
      auth_rd = 1'b0;
      run("R4 flush neither", 4'd4, 32'h1100, 3'd0, 1'b0, 1, CC, 4'h3, 0, 0);
      cap_default();
   endtask

   task automatic t_pcc();
      cap_default(); pcc_sysreg = 1'b0;
      run("R5 inval pcc perm", 4'd5, 32'h1100, 3'd0, 1'b0, 1, CC, 4'hB, 0, 0);
      run("R5 zero ignores pcc perm", 4'd6, 32'h1100, 3'd0, 1'b0, 0, 0, 4'h0, 0, 0);
      auth_rd = 1'b0;
      run("R5 auth perm first", 4'd5, 32'h1100, 3'd0, 1'b0, 1, CC, 4'h3, 0, 0);
      cap_default();
   endtask

   task automatic t_len();
      cap_default();
      run("R6 last word in", 4'd0, 32'h1FFC, 3'd2, 1'b0, 0, 0, 4'h0, 0, 0);
      run("R6 straddle top", 4'd0, 32'h1FFE, 3'd2, 1'b0, 1, CC, 4'h4, 0, 0);
      run("R6 below base", 4'd1, 32'h0FFF, 3'd0, 1'b0, 1, CC, 4'h4, 0, 0);
      run("R6 first byte in", 4'd2, 32'h1000, 3'd0, 1'b0, 0, 0, 4'h0, 0, 0);
   endtask

   task automatic t_blk();
      cap_default(); auth_base = 33'h1010;
      run("R7 zero partial block", 4'd6, 32'h1020, 3'd0, 1'b0, 1, CC, 4'h4, 0, 0);
      run("R7 inval partial block", 4'd5, 32'h1030, 3'd0, 1'b0, 1, CC, 4'h4, 0, 0);
      run("R7 clean partial block", 4'd3, 32'h1000, 3'd0, 1'b0, 0, 0, 4'h0, 0, 0);
      cap_default();
      run("R7 flush block outside", 4'd4, 32'h2010, 3'd0, 1'b0, 1, CC, 4'h4, 0, 0);
      run("R7 zero full block", 4'd6, 32'h1FC0, 3'd0, 1'b0, 0, 0, 4'h0, 0, 0);
   endtask

   task automatic t_align();
      cap_default();
      run("R8 cap load misaligned", 4'd0, 32'h1004, 3'd0, 1'b1, 1, 5'd4, 4'h0, 0, 0);
      run("R8 cap store misaligned", 4'd1, 32'h1004, 3'd0, 1'b1, 1, 5'd6, 4'h0, 0, 0);
      run("R8 cap load aligned", 4'd0, 32'h1008, 3'd0, 1'b1, 0, 0, 4'h0, 0, 0);
      run("R8 narrow load unaligned", 4'd0, 32'h1003, 3'd0, 1'b0, 0, 0, 4'h0, 0, 0);
      run("R9 length beats align", 4'd0, 32'h1FFC, 3'd0, 1'b1, 1, CC, 4'h4, 0, 0);
   endtask

   task automatic t_pf();
      cap_default(); auth_tag = 1'b0;
      run("R10 pf untagged", 4'd7, 32'h1100, 3'd0, 1'b0, 0, 0, 4'h0, 1, 0);
      cap_default(); auth_sealed = 1'b1;
      run("R10 pf sealed", 4'd8, 32'h1100, 3'd0, 1'b0, 0, 0, 4'h0, 1, 0);
      cap_default(); auth_wr = 1'b0;
      run("R10 pf write no perm", 4'd8, 32'h1100, 3'd0, 1'b0, 0, 0, 4'h0, 1, 0);
      run("R10 pf read ok", 4'd7, 32'h1100, 3'd0, 1'b0, 0, 0, 4'h0, 0, 0);
      cap_default(); auth_base = 33'h1010;
      run("R10 pf partial block", 4'd7, 32'h1000, 3'd0, 1'b0, 0, 0, 4'h0, 0, 0);
      run("R10 pf block outside", 4'd7, 32'h0FC0, 3'd0, 1'b0, 0, 0, 4'h0, 1, 0);
      cap_default();
   endtask

   task automatic t_strip();
      cap_default(); region_taggable = 1'b0;
      run("R11 load untaggable", 4'd0, 32'h1100, 3'd3, 1'b0, 0, 0, 4'h0, 0, 1);
      run("R11 store untaggable", 4'd1, 32'h1100, 3'd3, 1'b0, 0, 0, 4'h0, 0, 0);
      run("R11 faulting load", 4'd0, 32'h2000, 3'd3, 1'b0, 1, CC, 4'h4, 0, 0);
      cap_default();
      run("R11 load taggable", 4'd0, 32'h1100, 3'd3, 1'b0, 0, 0, 4'h0, 0, 0);
   endtask

   task automatic t_reserved();
      cap_default(); auth_tag = 1'b0;
      run("R12 reserved op", 4'd12, 32'h1100, 3'd0, 1'b0, 0, 0, 4'h0, 0, 0);
      cap_default();
      @(negedge clk);
      check("R12 idle quiet", {exc_valid, exc_code, cheri_cause, pf_drop, tag_strip}, 12'h000);
      total++;
      if (rsp_valid !== 1'b0) begin bad++; $display("FAIL R12 idle rsp_valid=%b expected 0", rsp_valid); end
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      bad++; total++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_tag();
      t_seal();
      t_perm();
      t_clean_perm();
      t_pcc();
      t_len();
      t_blk();
      t_align();
      t_pf();
      t_strip();
      t_reserved();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule